// File: doc/BRIEF.md
# Block Cipher Register Front-End (DES / Triple-DES)

This block sits between a 32-bit register bus and a 64-bit block cipher core. Software, or a pair of DMA channels, programs up to three 64-bit keys, an initialisation vector, a mode word and a byte count. It then moves each 64-bit block in and out through a pair of fixed data addresses, one 32-bit word at a time. The front-end accepts one block at a time. It applies the chaining arithmetic for cipher block chaining, runs the core once for single DES or three times for Triple-DES, and holds the result until software drains it.

Status flags in the mode word gate every transfer. An input-ready flag says a new block may be written. An output-ready flag says a result is waiting. Each direction has its own DMA request line with its own enable. In chaining mode the IV register is rewritten after each block with the chaining value. Reading it back and writing it into a later job continues the chain.

The cipher core is external. It receives a block, a key and a direction with a one-cycle start pulse, and later answers with a one-cycle done pulse and its output block.

Top module: `des_fe_top`

## Requirements
- R1: After reset, the mode word (offset 0x20), the byte count (0x24) and the DMA enable word (0x34) read 0. Offset 0x38 reads 1 in bit 0 from the first cycle after reset is released. Offset 0x30 reads the constant REV_ID.
- R2: The keys sit at these offsets: third key at 0x00/0x04, second key at 0x08/0x0C, first key at 0x10/0x14. The IV sits at 0x18/0x1C. In each pair the low word is first. Every one of these words reads back as written.
- R3: Mode-word bit 1 (input-ready) is 1 only while no block is in flight and the byte count is nonzero. It drops to 0 in the cycle after the high data word (0x2C) is written, and stays 0 until the result's high word has been read.
- R4: Mode-word bit 0 (output-ready) rises only after the core's final done pulse for the block. It clears after a read of the high data word.
- R5: With bit 3 = 0, a block runs a single core pass with the first key. Bit 2 selects the direction: 1 = encrypt, 0 = decrypt.
- R6: With bit 3 = 1, encryption runs the core passes key1-encrypt, key2-decrypt, key3-encrypt. Decryption runs key3-decrypt, key2-encrypt, key1-decrypt.
- R7: With bit 4 = 1 and encryption, the core input is the plaintext XOR the IV. After the block the IV holds the ciphertext.
- R8: With bit 4 = 1 and decryption, the result is the core output XOR the IV. After the block the IV holds the input ciphertext.
- R9: The byte count ignores bits [2:0] on write and drops by 8 at each completed block. While it is 0, data writes are ignored: no block starts and the held result is unchanged.
- R10: The input DMA request equals enable bit 5 AND input-ready. The output DMA request equals enable bit 6 AND output-ready. Writing 0 to offset 0x34 clears both requests.
- R11: The core start is a single-cycle pulse. Core input, key and direction stay stable until the core's done pulse.
- R12: A block is formed with its high half from the word at 0x2C and its low half from the word at 0x28. The result reads back low half at 0x28 and high half at 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reading offset 0x2C has a side effect) |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dma_in_req | output | 1 | Input DMA request |
| dma_out_req | output | 1 | Output DMA request |
| core_start | output | 1 | One-cycle start to the cipher core |
| core_encrypt | output | 1 | Core direction, 1 = encrypt |
| core_key | output | 64 | Key for the current pass |
| core_din | output | 64 | Core input block |
| core_done | input | 1 | One-cycle completion from the core |
| core_dout | input | 64 | Core output block |

## Verification
The bench builds the block with its default 8-bit address and the default REV_ID. The bench's own core model answers after a fixed latency of three cycles. Three passes per block and several blocks per job therefore complete quickly. This makes every combination of direction, chaining and Triple-DES reachable in a short run, along with zero-count writes and the DMA request edges. A toy reversible core function (key XOR plus byte rotation) makes any wrong key order, wrong pass direction or misplaced chaining XOR change the result.

// File: rtl/des_fe_pkg.sv
package des_fe_pkg;

    localparam int unsigned BLK_W     = 64;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BLK_BYTES = 8;
    localparam int unsigned NUM_KEYS  = 3;

    // byte offsets of the register bank
    localparam logic [7:0] OFS_KEY_BASE = 8'h00; // third key lowest, first key highest
    localparam logic [7:0] OFS_IV_LO    = 8'h18;
    localparam logic [7:0] OFS_IV_HI    = 8'h1C;
    localparam logic [7:0] OFS_MODE     = 8'h20;
    localparam logic [7:0] OFS_COUNT    = 8'h24;
    localparam logic [7:0] OFS_DAT_LO   = 8'h28;
    localparam logic [7:0] OFS_DAT_HI   = 8'h2C;
    localparam logic [7:0] OFS_REV      = 8'h30;
    localparam logic [7:0] OFS_DMA_EN   = 8'h34;
    localparam logic [7:0] OFS_STAT     = 8'h38;

    // mode word bit positions
    localparam int unsigned MB_OUT_RDY = 0;
    localparam int unsigned MB_IN_RDY  = 1;
    localparam int unsigned MB_ENC     = 2;
    localparam int unsigned MB_TRIPLE  = 3;
    localparam int unsigned MB_CHAIN   = 4;

    // DMA enable bit positions
    localparam int unsigned DB_IN  = 5;
    localparam int unsigned DB_OUT = 6;

    typedef struct packed {
        logic chain;
        logic triple;
        logic enc;
    } mode_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_HOLD
    } seq_e;

    // key slot for a pass: 0 = first key, 1 = second, 2 = third
    function automatic logic [1:0] key_slot(mode_t m, logic [1:0] pass);
        if (!m.triple)
            return 2'd0;
        return m.enc ? pass : 2'd2 - pass;
    endfunction

    // direction of a pass: middle pass of a triple run is inverted
    function automatic logic pass_dir(mode_t m, logic [1:0] pass);
        return m.enc ^ pass[0];
    endfunction

    function automatic logic final_pass(mode_t m, logic [1:0] pass);
        return m.triple ? (pass == 2'd2) : 1'b1;
    endfunction

    // byte offset of the low word of key slot i
    function automatic logic [7:0] key_lo_ofs(int unsigned i);
        return OFS_KEY_BASE + 8'((NUM_KEYS - 1 - i) * 8);
    endfunction

endpackage

// File: rtl/des_fe_regfile.sv
module des_fe_regfile
    import des_fe_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LEN_W  = 32,
    parameter logic [31:0] REV_ID = 32'h0000_0021
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                in_rdy,
    input  logic                out_rdy,
    input  logic [BLK_W-1:0]    result,
    input  logic                blk_done,
    input  logic                iv_upd,
    input  logic [BLK_W-1:0]    iv_next,
    output logic [BLK_W-1:0]    key_q [NUM_KEYS],
    output logic [BLK_W-1:0]    iv_q,
    output mode_t               mode_q,
    output logic                len_nz,
    output logic                en_in,
    output logic                en_out,
    output logic                wr_lo,
    output logic                wr_hi,
    output logic                rd_hi
);

    localparam logic [LEN_W-1:0] LEN_STEP = LEN_W'(BLK_BYTES);
    localparam logic [LEN_W-1:0] LEN_MASK = ~(LEN_STEP - LEN_W'(1));

    logic wr, rd;
    logic [LEN_W-1:0] len_q;
    logic stat_q;
    logic wr_len;

    assign wr = bus_sel && bus_wr;
    assign rd = bus_sel && bus_rd;

    function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wr_len = wr && hit(bus_addr, OFS_COUNT);
    assign wr_lo  = wr && hit(bus_addr, OFS_DAT_LO);
    assign wr_hi  = wr && hit(bus_addr, OFS_DAT_HI);
    assign rd_hi  = rd && hit(bus_addr, OFS_DAT_HI);
    assign len_nz = len_q != '0;

    // key registers, one slot per generate iteration
    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_key
        localparam logic [7:0] LO = key_lo_ofs(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                key_q[i] <= '0;
            end else if (wr && hit(bus_addr, LO)) begin
                key_q[i][31:0] <= bus_wdata;
            end else if (wr && hit(bus_addr, LO + 8'd4)) begin
                key_q[i][63:32] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iv_q   <= '0;
            mode_q <= '0;
            len_q  <= '0;
            en_in  <= 1'b0;
            en_out <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            stat_q <= 1'b1;
            if (wr && hit(bus_addr, OFS_IV_LO))
                iv_q[31:0] <= bus_wdata;
            else if (wr && hit(bus_addr, OFS_IV_HI))
                iv_q[63:32] <= bus_wdata;
            else if (iv_upd)
                iv_q <= iv_next;
            if (wr && hit(bus_addr, OFS_MODE)) begin
                mode_q.enc    <= bus_wdata[MB_ENC];
                mode_q.triple <= bus_wdata[MB_TRIPLE];
                mode_q.chain  <= bus_wdata[MB_CHAIN];
            end
            if (wr_len)
                len_q <= bus_wdata[LEN_W-1:0] & LEN_MASK;
            else if (blk_done && len_nz)
                len_q <= len_q - LEN_STEP;
            if (wr && hit(bus_addr, OFS_DMA_EN)) begin
                en_in  <= bus_wdata[DB_IN];
                en_out <= bus_wdata[DB_OUT];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (hit(bus_addr, key_lo_ofs(i)))        bus_rdata = key_q[i][31:0];
            if (hit(bus_addr, key_lo_ofs(i) + 8'd4)) bus_rdata = key_q[i][63:32];
        end
        if (hit(bus_addr, OFS_IV_LO))  bus_rdata = iv_q[31:0];
        if (hit(bus_addr, OFS_IV_HI))  bus_rdata = iv_q[63:32];
        if (hit(bus_addr, OFS_MODE)) begin
            bus_rdata[MB_OUT_RDY] = out_rdy;
            bus_rdata[MB_IN_RDY]  = in_rdy;
            bus_rdata[MB_ENC]     = mode_q.enc;
            bus_rdata[MB_TRIPLE]  = mode_q.triple;
            bus_rdata[MB_CHAIN]   = mode_q.chain;
        end
        if (hit(bus_addr, OFS_COUNT))  bus_rdata = WORD_W'(len_q);
        if (hit(bus_addr, OFS_DAT_LO)) bus_rdata = result[31:0];
        if (hit(bus_addr, OFS_DAT_HI)) bus_rdata = result[63:32];
        if (hit(bus_addr, OFS_REV))    bus_rdata = REV_ID;
        if (hit(bus_addr, OFS_DMA_EN)) begin
            bus_rdata[DB_IN]  = en_in;
            bus_rdata[DB_OUT] = en_out;
        end
        if (hit(bus_addr, OFS_STAT))   bus_rdata[0] = stat_q;
    end

    // R9: a finished block takes exactly one block of bytes off the count
    a_r9_len_step: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !wr_len && len_nz) |=> (len_q == $past(len_q) - LEN_STEP));

    // R9: the count never holds a partial block
    a_r9_len_aligned: assert property (@(posedge clk) disable iff (rst)
        (len_q & ~LEN_MASK) == '0);

endmodule

// File: rtl/des_fe_seq.sv
module des_fe_seq
    import des_fe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  mode_t              mode,
    input  logic [BLK_W-1:0]   iv,
    input  logic [BLK_W-1:0]   key_q [NUM_KEYS],
    input  logic               len_nz,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic               rd_hi,
    input  logic [WORD_W-1:0]  wdata,
    output logic               in_rdy,
    output logic               out_rdy,
    output logic [BLK_W-1:0]   result,
    output logic               blk_done,
    output logic               iv_upd,
    output logic [BLK_W-1:0]   iv_next,
    output logic               core_start,
    output logic               core_encrypt,
    output logic [BLK_W-1:0]   core_key,
    output logic [BLK_W-1:0]   core_din,
    input  logic               core_done,
    input  logic [BLK_W-1:0]   core_dout
);

    seq_e              state;
    mode_t             mq;
    logic [1:0]        pass;
    logic [BLK_W-1:0]  cur, raw;
    logic [WORD_W-1:0] lo_buf;
    logic [BLK_W-1:0]  blk_in;
    logic              accept;

    assign in_rdy   = (state == SQ_IDLE) && len_nz;
    assign out_rdy  = (state == SQ_HOLD);
    assign accept   = in_rdy && wr_hi;
    assign blk_in   = {wdata, lo_buf};
    assign blk_done = (state == SQ_WAIT) && core_done && final_pass(mq, pass);
    assign iv_upd   = blk_done && mq.chain;
    assign iv_next  = mq.enc ? core_dout : raw;

    assign core_start   = (state == SQ_ISSUE);
    assign core_din     = cur;
    assign core_encrypt = pass_dir(mq, pass);
    assign core_key     = key_q[key_slot(mq, pass)];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            mq     <= '0;
            pass   <= '0;
            cur    <= '0;
            raw    <= '0;
            lo_buf <= '0;
            result <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (wr_lo && len_nz)
                        lo_buf <= wdata;
                    if (accept) begin
                        raw   <= blk_in;
                        cur   <= (mode.chain && mode.enc) ? (blk_in ^ iv) : blk_in;
                        mq    <= mode;
                        pass  <= '0;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (core_done) begin
                        if (final_pass(mq, pass)) begin
                            result <= (mq.chain && !mq.enc) ? (core_dout ^ iv) : core_dout;
                            state  <= SQ_HOLD;
                        end else begin
                            cur   <= core_dout;
                            pass  <= pass + 2'd1;
                            state <= SQ_ISSUE;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (rd_hi)
                        state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R11: start lasts one cycle
    a_r11_start_pulse: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    // R11: operands held while the core works
    a_r11_operands_hold: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT && !core_done) |=>
            ($stable(core_din) && $stable(core_key) && $stable(core_encrypt)));

    // R4: a result only appears after the core has answered
    a_r4_ready_after_core: assert property (@(posedge clk) disable iff (rst)
        $rose(out_rdy) |-> $past(core_done));

    // R3: taking a block closes the input side at once
    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_rdy);

endmodule

// File: rtl/des_fe_top.sv
module des_fe_top
    import des_fe_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LEN_W  = 32,
    parameter logic [31:0] REV_ID = 32'h0000_0021
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              dma_in_req,
    output logic              dma_out_req,
    output logic              core_start,
    output logic              core_encrypt,
    output logic [63:0]       core_key,
    output logic [63:0]       core_din,
    input  logic              core_done,
    input  logic [63:0]       core_dout
);

    logic [BLK_W-1:0] key_q [NUM_KEYS];
    logic [BLK_W-1:0] iv_q, result, iv_next;
    mode_t            mode_q;
    logic             len_nz, en_in, en_out;
    logic             wr_lo, wr_hi, rd_hi;
    logic             in_rdy, out_rdy, blk_done, iv_upd;

    des_fe_regfile #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .REV_ID (REV_ID)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_rdy    (in_rdy),
        .out_rdy   (out_rdy),
        .result    (result),
        .blk_done  (blk_done),
        .iv_upd    (iv_upd),
        .iv_next   (iv_next),
        .key_q     (key_q),
        .iv_q      (iv_q),
        .mode_q    (mode_q),
        .len_nz    (len_nz),
        .en_in     (en_in),
        .en_out    (en_out),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rd_hi     (rd_hi)
    );

    des_fe_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode_q),
        .iv           (iv_q),
        .key_q        (key_q),
        .len_nz       (len_nz),
        .wr_lo        (wr_lo),
        .wr_hi        (wr_hi),
        .rd_hi        (rd_hi),
        .wdata        (bus_wdata),
        .in_rdy       (in_rdy),
        .out_rdy      (out_rdy),
        .result       (result),
        .blk_done     (blk_done),
        .iv_upd       (iv_upd),
        .iv_next      (iv_next),
        .core_start   (core_start),
        .core_encrypt (core_encrypt),
        .core_key     (core_key),
        .core_din     (core_din),
        .core_done    (core_done),
        .core_dout    (core_dout)
    );

    assign dma_in_req  = en_in && in_rdy;
    assign dma_out_req = en_out && out_rdy;

    // R10: a request for new input never overlaps core activity or a waiting result
    a_r10_in_req_quiet: assert property (@(posedge clk) disable iff (rst)
        dma_in_req |-> (!core_start && !dma_out_req));

    // R10: the output request drops after the result's high word is read
    a_r10_out_req_drops: assert property (@(posedge clk) disable iff (rst)
        (dma_out_req && bus_sel && bus_rd && bus_addr == ADDR_W'(OFS_DAT_HI)) |=> !dma_out_req);

endmodule

// File: tb/des_fe_top_bench.sv
`timescale 1ns/1ps
module des_fe_top_bench;

    localparam real         CYC     = 8.0;
    localparam int          LAT     = 3;
    localparam logic [31:0] REV_EXP = 32'h0000_0021;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dma_in_req, dma_out_req;
    logic        core_start, core_encrypt, core_done;
    logic [63:0] core_key, core_din, core_dout;

    always #(CYC/2) clk = ~clk;

    des_fe_top u_des_fe_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .core_start(core_start), .core_encrypt(core_encrypt), .core_key(core_key),
        .core_din(core_din), .core_done(core_done), .core_dout(core_dout)
    );

    // toy reversible core: encrypt = rotate-left-8 of (x ^ k), decrypt inverts it
    function automatic logic [63:0] cf(logic [63:0] x, logic [63:0] k, logic e);
        logic [63:0] t;
        if (e) begin
            t = x ^ k;
            return {t[55:0], t[63:56]};
        end
        t = {x[7:0], x[63:8]};
        return t ^ k;
    endfunction

    int chks = 0, errs = 0;
    int core_chks = 0, core_errs = 0;
    int clk_chks = 0, clk_errs = 0;
    bit finished = 0;

    // ---------------- core model ----------------
    bit          c_busy = 0;
    int          c_cnt = 0;
    logic [63:0] c_din, c_key;
    logic        c_enc;

    always @(posedge clk) begin
        if (rst) begin
            c_busy    <= 0;
            core_done <= 1'b0;
            core_dout <= '0;
        end else begin
            core_done <= 1'b0;
            if (core_start) begin
                core_chks <= core_chks + 1;
                if (c_busy) begin
                    core_errs <= core_errs + 1;
                    $display("FAIL R11: start while core busy (got start=1 expected 0)");
                end
                c_busy <= 1; c_cnt <= LAT;
                c_din <= core_din; c_key <= core_key; c_enc <= core_encrypt;
            end else if (c_busy) begin
                core_chks <= core_chks + 1;
                if (core_din !== c_din || core_key !== c_key || core_encrypt !== c_enc) begin
                    core_errs <= core_errs + 1;
                    $display("FAIL R11: operands moved got %h expected %h", core_din, c_din);
                end
                if (c_cnt == 1) begin
                    core_done <= 1'b1;
                    core_dout <= cf(c_din, c_key, c_enc);
                    c_busy    <= 0;
                end else begin
                    c_cnt <= c_cnt - 1;
                end
            end
        end
    end

    // ---------------- per-clock request model ----------------
    bit         m_track = 0;
    bit         m_en_in = 0, m_en_out = 0, m_busy = 0, m_res = 0;
    logic [31:0] m_len = 0;

    always @(negedge clk) begin
        if (!rst && m_track) begin
            clk_chks = clk_chks + 1;
            if (dma_in_req !== (m_en_in && !m_busy && m_len != 0)) begin
                clk_errs = clk_errs + 1;
                $display("FAIL R10: dma_in_req got %b expected %b", dma_in_req,
                         (m_en_in && !m_busy && m_len != 0));
            end
            if (!m_busy && dma_out_req !== 1'b0) begin
                clk_errs = clk_errs + 1;
                $display("FAIL R10: dma_out_req got %b expected 0", dma_out_req);
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        chks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        if (a == 8'h24) m_len = d & ~32'h7;
        if (a == 8'h34) begin m_en_in = d[5]; m_en_out = d[6]; end
        if (a == 8'h2C && !m_busy && m_len != 0) m_busy = 1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        if (a == 8'h2C && m_res) begin
            m_res = 0; m_busy = 0; m_len = m_len - 8;
        end
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic wr64(input logic [7:0] a, input logic [63:0] v);
        wr(a, v[31:0]);
        wr(a + 8'd4, v[63:32]);
    endtask

    task automatic rd64(input logic [7:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 8'd4, hi);
        v = {hi, lo};
    endtask

    task automatic wait_out(input string req);
        logic [31:0] s;
        for (int i = 0; i < 60; i++) begin
            rd(8'h20, s);
            if (s[0]) begin m_res = 1; break; end
        end
        check(req, 64'(s[0]), 64'd1);
    endtask

    // one block through the data port; checks R3/R4 around it
    task automatic run_block(input logic [63:0] blk, output logic [63:0] res);
        logic [31:0] s, lo, hi;
        wr(8'h28, blk[31:0]);
        wr(8'h2C, blk[63:32]);
        rd(8'h20, s);
        check("R3 input-ready low after block write", 64'(s[1]), 64'd0);
        wait_out("R4 output-ready after block");
        rd(8'h28, lo);
        rd(8'h2C, hi);   // R12: low word first, high word releases
        res = {hi, lo};
        rd(8'h20, s);
        check("R4 output-ready cleared by high read", 64'(s[0]), 64'd0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks",
                     errs + core_errs + clk_errs, chks + core_chks + clk_chks);
            $finish;
        end
    endtask

    initial begin
        #(CYC * 150000);
        chks++; errs++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    // ---------------- main sequence ----------------
    logic [63:0] K1 = 64'h0123_4567_89AB_CDEF;
    logic [63:0] K2 = 64'hF0E1_D2C3_B4A5_9687;
    logic [63:0] K3 = 64'h1357_9BDF_2468_ACE0;
    logic [63:0] IV0 = 64'hA5A5_0F0F_5A5A_F0F0;

    initial begin
        logic [31:0] s;
        logic [63:0] v, r, r2, c0, c1, iv, exp;
        logic [63:0] p0, p1;
        p0 = 64'h1122_3344_5566_7788;
        p1 = 64'hCAFE_BABE_DEAD_BEEF;

        repeat (4) @(posedge clk);
        #1 rst = 0;
        m_track = 1;

        // R1 reset state
        rd(8'h20, s); check("R1 mode word after reset", 64'(s), 64'd0);
        rd(8'h24, s); check("R1 byte count after reset", 64'(s), 64'd0);
        rd(8'h34, s); check("R1 dma enables after reset", 64'(s), 64'd0);
        rd(8'h38, s); check("R1 reset-complete bit", 64'(s[0]), 64'd1);
        rd(8'h30, s); check("R1 revision constant", 64'(s), 64'(REV_EXP));

        // R2 key / IV placement
        wr64(8'h10, K1); wr64(8'h08, K2); wr64(8'h00, K3); wr64(8'h18, IV0);
        rd64(8'h10, v); check("R2 first key at 0x10", v, K1);
        rd64(8'h08, v); check("R2 second key at 0x08", v, K2);
        rd64(8'h00, v); check("R2 third key at 0x00", v, K3);
        rd64(8'h18, v); check("R2 IV at 0x18", v, IV0);

        // R5 / R12 single ECB encrypt, two blocks
        wr(8'h20, 32'h04);
        wr(8'h24, 32'd16);
        rd(8'h20, s); check("R3 input-ready with count", 64'(s[1]), 64'd1);
        run_block(p0, r); check("R5 R12 single encrypt block0", r, cf(p0, K1, 1));
        run_block(p1, r); check("R5 single encrypt block1", r, cf(p1, K1, 1));
        rd(8'h24, s); check("R9 count reaches zero", 64'(s), 64'd0);
        rd(8'h20, s); check("R3 input-ready low at zero count", 64'(s[1]), 64'd0);

        // R9 data ignored at zero count
        wr(8'h28, 32'h1111_1111); wr(8'h2C, 32'h2222_2222);
        repeat (12) @(posedge clk);
        rd(8'h20, s); check("R9 no block started at zero count", 64'(s[1:0]), 64'd0);
        rd64(8'h28, v); check("R9 held result unchanged", v, cf(p1, K1, 1));

        // R5 single decrypt
        wr(8'h20, 32'h00);
        wr(8'h24, 32'd8);
        run_block(p0, r); check("R5 single decrypt", r, cf(p0, K1, 0));

        // R6 triple encrypt and decrypt
        wr(8'h20, 32'h0C);
        wr(8'h24, 32'd8);
        run_block(p1, r);
        exp = cf(cf(cf(p1, K1, 1), K2, 0), K3, 1);
        check("R6 triple encrypt order", r, exp);
        wr(8'h20, 32'h08);
        wr(8'h24, 32'd8);
        run_block(r, r2);
        check("R6 triple decrypt order", r2, cf(cf(cf(r, K3, 0), K2, 1), K1, 0));
        check("R6 triple round trip", r2, p1);

        // R7 chaining encrypt
        wr(8'h20, 32'h14);
        wr64(8'h18, IV0);
        wr(8'h24, 32'd16);
        iv = IV0;
        run_block(p0, c0); exp = cf(p0 ^ iv, K1, 1); check("R7 chain encrypt block0", c0, exp);
        iv = c0;
        run_block(p1, c1); exp = cf(p1 ^ iv, K1, 1); check("R7 chain encrypt block1", c1, exp);
        rd64(8'h18, v); check("R7 IV holds last ciphertext", v, c1);

        // R8 chaining decrypt, resumed from a saved IV
        wr(8'h20, 32'h10);
        wr64(8'h18, IV0);
        wr(8'h24, 32'd8);
        run_block(c0, r); check("R8 chain decrypt block0", r, p0);
        rd64(8'h18, v); check("R8 IV holds input ciphertext", v, c0);
        wr(8'h24, 32'd8);
        run_block(c1, r); check("R8 chain decrypt resumed", r, p1);

        // R10 DMA requests
        wr(8'h20, 32'h04);
        wr(8'h34, 32'h60);
        rd(8'h34, s); check("R10 enable readback", 64'(s), 64'h60);
        wr(8'h24, 32'd8);
        @(negedge clk); check("R10 input request raised", 64'(dma_in_req), 64'd1);
        wr(8'h28, p0[31:0]); wr(8'h2C, p0[63:32]);
        @(negedge clk); check("R10 input request dropped", 64'(dma_in_req), 64'd0);
        for (int i = 0; i < 40 && !dma_out_req; i++) @(negedge clk);
        check("R10 output request raised", 64'(dma_out_req), 64'd1);
        m_res = 1;
        rd64(8'h28, r); check("R10 dma-path result", r, cf(p0, K1, 1));
        @(negedge clk); check("R10 output request dropped", 64'(dma_out_req), 64'd0);
        wr(8'h24, 32'd8);
        @(negedge clk); check("R10 input request on reload", 64'(dma_in_req), 64'd1);
        wr(8'h34, 32'h0);
        @(negedge clk); check("R10 zero write clears request", 64'(dma_in_req), 64'd0);

        // R9 alignment of the count
        wr(8'h24, 32'h13);
        rd(8'h24, s); check("R9 count low bits dropped", 64'(s), 64'h10);
        wr(8'h24, 32'h0);

        repeat (4) @(posedge clk);
        report();
    end

endmodule